// File: doc/BRIEF.md
# Quadruple-Modulus Swallow N Divider

This block sits after a four-modulus prescaler. It divides the prescaler output clock so that one output period spans N cycles of the high-frequency input. The block is clocked by the prescaler output. In every prescaler cycle it drives a two-bit modulus request, and the prescaler then divides that cycle by P, P+1, P+4 or P+5. The base modulus P is 16 or 8, chosen by a mode bit that the block passes through to the prescaler.

A period lasts C prescaler cycles. The +1 request is raised for the first A cycles of the period and the +4 request for the first B cycles, so the two together give +5. A fractional accumulator adds the fractional word once per period. When that addition overflows, the next period raises the +1 request for one extra cycle. The divide words, the fractional word and the prescaler mode are latched only at a period boundary. A counter-reset input and a power-down input stop the divider, and a flag reports a loaded word set whose C is too small for its swallow counts.

Top module: `quad_mod_ndiv`

## Requirements
- R1: While rst_n is low, mod_ctl is 0, div_pulse is 0, cfg_invalid is 0 and presc_mode is 0.
- R2: When running, div_pulse is high for exactly one prescaler cycle per period, on the last of C consecutive cycles of that period.
- R3: Cycles in a period are indexed from 0. mod_ctl bit 0 (+1 request) is high in cycles 0 up to A+k-1, where k is the fractional carry of the period. mod_ctl bit 1 (+4 request) is high in cycles 0 up to B-1. Both bits high means +5.
- R4: presc_mode is the latched mode bit, and P is 16 when it is 1 and 8 when it is 0. The sum of the moduli requested over one period equals P·C + 4·B + A + k.
- R5: At each period end, the fractional word is added to a 4-bit accumulator. A carry out sets k=1 for the following period. Counter reset clears the accumulator, so k=0 in the first period after a reset.
- R6: Input word changes during a period have no effect until the cycle after the next div_pulse. Words present at the edge that ends the pulse cycle govern the next period.
- R7: While cnt_rst is high, div_pulse and mod_ctl are 0 and the words are latched every cycle. After release, a new period starts at cycle 0.
- R8: While pwr_dn is high (and cnt_rst low), div_pulse and mod_ctl are 0 and the cycle index is frozen. After release, the period resumes from the same index.
- R9: cfg_invalid is 1 exactly when the latched C is less than max(A, B) + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_word | input | 11 | Period length in prescaler cycles (C) |
| b_word | input | 2 | Count of +4 cycles per period (B) |
| a_word | input | 2 | Count of +1 cycles per period (A) |
| frac_word | input | 4 | Fractional increment per period |
| presc_sel | input | 1 | Prescaler mode: 1 selects base 16, 0 selects base 8 |
| cnt_rst | input | 1 | Counter reset, active high |
| pwr_dn | input | 1 | Divider power-down, active high |
| mod_ctl | output | 2 | Modulus request: bit 0 adds 1, bit 1 adds 4 |
| presc_mode | output | 1 | Latched prescaler mode |
| div_pulse | output | 1 | One-cycle pulse per divided period |
| cfg_invalid | output | 1 | Latched words violate C ≥ max(A,B)+2 |

## Verification
Two events can land in the same edge: the end-of-period reload of the divide words, and the fractional carry update that lengthens the next +1 run. Both can also coincide with a counter reset or a power-down arriving on the pulse cycle. The stimulus changes words at random points inside periods, raises the fractional word to its maximum, and starts random reset and power-down bursts. The cycles requested by the design are summed through a behavioural prescaler, and each period's sum is compared against the formula using words latched by the bench's own model at pulse boundaries.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
  localparam int unsigned MOD_P1 = 0;
  localparam int unsigned MOD_P4 = 1;

  function automatic int unsigned min_period(input int unsigned a, input int unsigned b);
    return ((a > b) ? a : b) + 2;
  endfunction
endpackage

// File: rtl/ndiv_cfg_latch.sv
module ndiv_cfg_latch
  import ndiv_pkg::*;
#(
  parameter int unsigned C_W = 11,
  parameter int unsigned S_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [C_W-1:0] c_in,
  input  logic [S_W-1:0] b_in,
  input  logic [S_W-1:0] a_in,
  input  logic           sel_in,
  output logic [C_W-1:0] c_q,
  output logic [S_W-1:0] b_q,
  output logic [S_W-1:0] a_q,
  output logic           sel_q,
  output logic           inv_q
);
  logic [C_W-1:0] c_d;
  logic [S_W-1:0] b_d, a_d;
  logic           sel_d, inv_d;

  always_comb begin
    c_d   = c_q;
    b_d   = b_q;
    a_d   = a_q;
    sel_d = sel_q;
    inv_d = inv_q;
    if (load) begin
      c_d   = c_in;
      b_d   = b_in;
      a_d   = a_in;
      sel_d = sel_in;
      inv_d = (32'(c_in) < min_period(32'(a_in), 32'(b_in)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= '0;
      b_q   <= '0;
      a_q   <= '0;
      sel_q <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      c_q   <= c_d;
      b_q   <= b_d;
      a_q   <= a_d;
      sel_q <= sel_d;
      inv_q <= inv_d;
    end
  end

  AST_INV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> (32'(c_q) < min_period(32'(a_q), 32'(b_q)))); // R9
endmodule

// File: rtl/ndiv_frac_acc.sv
module ndiv_frac_acc #(
  parameter int unsigned F_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           step,
  input  logic [F_W-1:0] frac_in,
  output logic           carry_q
);
  logic [F_W-1:0] acc_q, acc_d;
  logic           carry_d;
  logic [F_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac_in};

  always_comb begin
    acc_d   = acc_q;
    carry_d = carry_q;
    if (clr) begin
      acc_d   = '0;
      carry_d = 1'b0;
    end else if (step) begin
      acc_d   = sum[F_W-1:0];
      carry_d = sum[F_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  AST_CARRY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !carry_q); // R5
endmodule

// File: rtl/ndiv_period_ctr.sv
module ndiv_period_ctr
  import ndiv_pkg::*;
#(
  parameter int unsigned C_W = 11,
  parameter int unsigned S_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           en,
  input  logic [C_W-1:0] c_len,
  input  logic [S_W-1:0] b_cnt,
  input  logic [S_W:0]   a_eff,
  output logic [C_W-1:0] idx_q,
  output logic           last,
  output logic [1:0]     mod_raw
);
  localparam int unsigned PAD = C_W - S_W - 1;

  logic [C_W-1:0] idx_d;
  logic [C_W:0]   idx_inc;

  assign idx_inc = {1'b0, idx_q} + {{C_W{1'b0}}, 1'b1};
  assign last    = (idx_inc >= {1'b0, c_len});

  always_comb begin
    mod_raw         = '0;
    mod_raw[MOD_P1] = (idx_q < {{PAD{1'b0}}, a_eff});
    mod_raw[MOD_P4] = (idx_q < {{(PAD + 1){1'b0}}, b_cnt});
  end

  always_comb begin
    idx_d = idx_q;
    if (hold)
      idx_d = '0;
    else if (en)
      idx_d = last ? '0 : idx_inc[C_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (c_len != '0)) |-> (idx_q < c_len)); // R2
  AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hold && last) |=> (idx_q == '0)); // R2
  AST_FREEZE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !hold) |=> $stable(idx_q)); // R8
endmodule

// File: rtl/quad_mod_ndiv.sv
module quad_mod_ndiv
  import ndiv_pkg::*;
#(
  parameter int unsigned C_W = 11,
  parameter int unsigned S_W = 2,
  parameter int unsigned F_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [C_W-1:0] c_word,
  input  logic [S_W-1:0] b_word,
  input  logic [S_W-1:0] a_word,
  input  logic [F_W-1:0] frac_word,
  input  logic           presc_sel,
  input  logic           cnt_rst,
  input  logic           pwr_dn,
  output logic [1:0]     mod_ctl,
  output logic           presc_mode,
  output logic           div_pulse,
  output logic           cfg_invalid
);
  logic           rst_m, rst_s;
  logic           primed_q, primed_d;
  logic           hold, active, load, last, carry;
  logic [C_W-1:0] c_act, idx;
  logic [S_W-1:0] b_act, a_act;
  logic [S_W:0]   a_eff;
  logic           sel_act, inv_act;
  logic [1:0]     mod_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign primed_d = 1'b1;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) primed_q <= 1'b0;
    else        primed_q <= primed_d;
  end

  assign hold   = cnt_rst | ~primed_q;
  assign active = ~hold & ~pwr_dn;
  assign load   = hold | (active & last);
  assign a_eff  = {1'b0, a_act} + {{S_W{1'b0}}, carry};

  ndiv_cfg_latch #(.C_W(C_W), .S_W(S_W)) cfg_i (
    .clk    (clk),
    .rst_n  (rst_s),
    .load   (load),
    .c_in   (c_word),
    .b_in   (b_word),
    .a_in   (a_word),
    .sel_in (presc_sel),
    .c_q    (c_act),
    .b_q    (b_act),
    .a_q    (a_act),
    .sel_q  (sel_act),
    .inv_q  (inv_act)
  );

  ndiv_frac_acc #(.F_W(F_W)) frac_i (
    .clk     (clk),
    .rst_n   (rst_s),
    .clr     (hold),
    .step    (active & last),
    .frac_in (frac_word),
    .carry_q (carry)
  );

  ndiv_period_ctr #(.C_W(C_W), .S_W(S_W)) ctr_i (
    .clk     (clk),
    .rst_n   (rst_s),
    .hold    (hold),
    .en      (active),
    .c_len   (c_act),
    .b_cnt   (b_act),
    .a_eff   (a_eff),
    .idx_q   (idx),
    .last    (last),
    .mod_raw (mod_raw)
  );

  assign mod_ctl     = active ? mod_raw : 2'b00;
  assign div_pulse   = active & last;
  assign presc_mode  = sel_act;
  assign cfg_invalid = inv_act;

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_s)
    (active && !last) |=> ($stable(c_act) && $stable(b_act) && $stable(a_act) && $stable(sel_act))); // R6
  AST_PLUS4_EARLY: assert property (@(posedge clk) disable iff (!rst_s)
    mod_ctl[MOD_P4] |-> (32'(idx) < 32'(b_act))); // R3
endmodule

// File: tb/quad_mod_ndiv_tb_top.sv
`timescale 1ns/1ps
module quad_mod_ndiv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] c_word;
  logic [1:0]  b_word, a_word;
  logic [3:0]  frac_word;
  logic        presc_sel, cnt_rst, pwr_dn;
  logic [1:0]  mod_ctl;
  logic        presc_mode, div_pulse, cfg_invalid;

  always #4 clk = ~clk;

  quad_mod_ndiv dut_i (
    .clk(clk), .rst_n(rst_n), .c_word(c_word), .b_word(b_word), .a_word(a_word),
    .frac_word(frac_word), .presc_sel(presc_sel), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
    .mod_ctl(mod_ctl), .presc_mode(presc_mode), .div_pulse(div_pulse), .cfg_invalid(cfg_invalid)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  // next input values, applied at a falling edge
  int n_c, n_b, n_a, n_f; bit n_sel, n_rst, n_pd;
  // bench model
  int m_c, m_b, m_a, m_p, bidx, acc, carry, sum; bit m_sel, m_inv, loaded;
  int pd_left = 0, cr_left = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int need_c(input int a, input int b);
    return ((a > b) ? a : b) + 2;
  endfunction

  task automatic rand_cfg();
    n_a = $urandom % 4; n_b = $urandom % 4; n_f = $urandom % 16; n_sel = $urandom % 2;
    if ($urandom % 40 == 0) n_c = 200 + $urandom % 300;
    else                    n_c = need_c(n_a, n_b) + $urandom % 30;
  endtask

  task automatic set_cfg(input int c, input int b, input int a, input int f, input bit sel);
    n_c = c; n_b = b; n_a = a; n_f = f; n_sel = sel;
  endtask

  task automatic model_load();
    m_c = c_word; m_b = b_word; m_a = a_word; m_sel = presc_sel;
    m_p = presc_sel ? 16 : 8;
    m_inv = (m_c < need_c(m_a, m_b));
    loaded = 1'b1;
  endtask

  task automatic check_cycle();
    bit act, e_pulse, e_m0, e_m1, differ;
    string rq;
    act     = !pwr_dn && !cnt_rst;
    e_pulse = act && (bidx == m_c - 1);
    e_m0    = act && (bidx < m_a + carry);
    e_m1    = act && (bidx < m_b);
    differ  = (c_word != m_c) || (b_word != m_b) || (a_word != m_a) || (presc_sel != m_sel);
    rq = cnt_rst ? "R7" : (pwr_dn ? "R8" : (differ ? "R6" : "R2"));
    chk(div_pulse == e_pulse, rq, div_pulse, e_pulse);
    rq = cnt_rst ? "R7" : (pwr_dn ? "R8" : (differ ? "R6" : "R3"));
    chk(mod_ctl[0] == e_m0, rq, mod_ctl[0], e_m0);
    chk(mod_ctl[1] == e_m1, rq, mod_ctl[1], e_m1);
    if (loaded) begin
      chk(cfg_invalid == m_inv, "R9", cfg_invalid, m_inv);
      chk(presc_mode == m_sel, "R4", presc_mode, m_sel);
    end
    if (act) sum += (presc_mode ? 16 : 8) + int'(mod_ctl[0]) + 4 * int'(mod_ctl[1]);
    if (e_pulse && div_pulse) begin
      int exp_n;
      exp_n = m_p * m_c + 4 * m_b + m_a + carry;
      chk(sum == exp_n, carry ? "R5" : "R4", sum, exp_n);
    end
    // model advance for the coming rising edge
    if (cnt_rst) begin
      model_load(); bidx = 0; acc = 0; carry = 0; sum = 0;
    end else if (act) begin
      if (bidx == m_c - 1) begin
        int s;
        model_load();
        s = acc + int'(frac_word);
        carry = s >> 4; acc = s & 15; bidx = 0; sum = 0;
      end else bidx++;
    end
  endtask

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rnd) begin
        if ($urandom % 60 == 0) rand_cfg();
        if (pd_left > 0) pd_left--; else if ($urandom % 150 == 0) pd_left = 1 + $urandom % 10;
        if (cr_left > 0) cr_left--; else if ($urandom % 300 == 0) cr_left = 1 + $urandom % 3;
        n_pd = (pd_left > 0); n_rst = (cr_left > 0);
      end
      c_word = 11'(n_c); b_word = 2'(n_b); a_word = 2'(n_a); frac_word = 4'(n_f);
      presc_sel = n_sel; cnt_rst = n_rst; pwr_dn = n_pd;
      #1 check_cycle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    loaded = 1'b0; bidx = 0; acc = 0; carry = 0; sum = 0;
    m_c = 1; m_b = 0; m_a = 0; m_p = 8; m_sel = 0; m_inv = 0;
    rst_n = 1'b0;
    set_cfg(10, 1, 2, 0, 1'b1); n_rst = 1'b1; n_pd = 1'b0;
    c_word = 11'd10; b_word = 2'd1; a_word = 2'd2; frac_word = 4'd0;
    presc_sel = 1'b1; cnt_rst = 1'b1; pwr_dn = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mod_ctl == 2'b00, "R1", mod_ctl, 0);
    chk(div_pulse == 1'b0, "R1", div_pulse, 0);
    chk(cfg_invalid == 1'b0, "R1", cfg_invalid, 0);
    chk(presc_mode == 1'b0, "R1", presc_mode, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run(2, 0);
    n_rst = 1'b0;
    run(60, 0);                       // R2 R3 R4 base 16
    set_cfg(7, 2, 1, 0, 1'b0); run(45, 0); // R6 change mid-period, base 8
    // R9 flag corners under counter reset
    n_rst = 1'b1;
    set_cfg(3, 0, 2, 0, 1'b1); run(2, 0);
    set_cfg(4, 2, 2, 0, 1'b1); run(2, 0);
    set_cfg(2, 1, 0, 0, 1'b0); run(2, 0);
    set_cfg(0, 0, 0, 0, 1'b0); run(2, 0);
    set_cfg(2, 0, 0, 0, 1'b0); run(2, 0);
    n_rst = 1'b0; run(20, 0);         // minimum period
    // R5 maximal fractional with full swallow counts
    n_rst = 1'b1; set_cfg(5, 3, 3, 15, 1'b1); run(2, 0);
    n_rst = 1'b0; run(80, 0);
    set_cfg(9, 0, 1, 9, 1'b0); run(90, 0);
    // R8 power-down in mid period, then resume
    n_pd = 1'b1; run(7, 0); n_pd = 1'b0; run(30, 0);
    // R7 counter reset in mid period
    run(4, 0); n_rst = 1'b1; run(3, 0); n_rst = 1'b0; run(30, 0);
    // longest period
    set_cfg(2047, 3, 2, 5, 1'b1); run(2 * 2047 + 20, 0);
    set_cfg(12, 1, 1, 3, 1'b0); run(2100, 0);
    run(30000, 1);
    n_pd = 1'b0; n_rst = 1'b0; pd_left = 0; cr_left = 0;
    run(600, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule